// File: doc/BRIEF.md
# Clock-Phase Candidate Arbiter

Several decoder candidates run side by side, each locked to a different clock phase of the same data stream. Each one reports decoded groups. A report carries a station identifier (PI), a name-segment index, two characters of name text, a running quality score and a flag that says whether the group changed anything. The arbiter picks one candidate, the incumbent, whose view of the station is published. Publication covers a committed PI code and the four-segment programme-service name.

Selection favours whoever already holds the post. The incumbent wins ties, and its score is tracked even when its groups change nothing. A challenger takes over only with a strictly higher score, so one lucky false group cannot unseat a good candidate. A PI value is published only after it has been observed twice in a row. Each candidate keeps its own segment store. The name is shown only when the incumbent has seen all four segments.

Top module: `cand_arbiter`

## Requirements
- R1: After synchronous reset, sel_valid, pi_valid and ps_valid are 0 and no segment flag is set.
- R2: With no incumbent, the lowest-index candidate reporting a valid group becomes the incumbent. Its score becomes the best score, and from then on sel_valid stays 1 until reset.
- R3: A changed group from the incumbent whose score equals the best score is applied and counts as a PI observation.
- R4: A non-incumbent takes over only when its score is strictly greater than the best score. At equal score, nothing switches.
- R5: Every group from the incumbent sets the best score to that group's score, including groups with the changed flag at 0. Those groups count as no PI observation.
- R6: A PI observation comes from the acting candidate's changed group whose score is at least the best score. The PI becomes pi_code with pi_valid 1 on the 2nd consecutive observation of the same value. A differing value restarts the count, and the previously committed code is held meanwhile.
- R7: Every valid group with the changed flag at 1, from any candidate, stores its 16-bit text in that candidate's slot for the given segment (0 to 3) and sets that slot's seen flag.
- R8: ps_valid is 1 only when all four seen flags of the incumbent are set. ps_name holds segment 0 in bits [63:48], segment 1 in [47:32], segment 2 in [31:16] and segment 3 in [15:0].
- R9: Only one candidate acts per cycle: the lowest-index one that is eligible (any valid one when there is no incumbent, otherwise the incumbent or a challenger that beats the best score).
- R10: After a take-over, ps_valid and ps_name follow the new incumbent's own segment store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | N_CAND | One-cycle group strobe per candidate |
| grp_pi | input | N_CAND*16 | PI of each candidate's group |
| grp_seg | input | N_CAND*2 | Name-segment index per candidate |
| grp_text | input | N_CAND*16 | Two characters of name text per candidate |
| grp_score | input | N_CAND*16 | Candidate score, unsigned |
| grp_changed | input | N_CAND | Group changed the candidate's state |
| sel_valid | output | 1 | An incumbent exists |
| sel_idx | output | 3 | Incumbent index |
| pi_valid | output | 1 | pi_code holds a committed value |
| pi_code | output | 16 | Committed PI |
| ps_valid | output | 1 | Incumbent has all four segments |
| ps_name | output | 64 | Assembled service name |

## Verification
Some properties hold on every cycle and the embedded assertions check them. Once sel_valid is set it stays set. Any change of incumbent comes with a strictly larger best score. pi_code moves only in the cycle after an observation. ps_valid never appears without an incumbent.

Other behaviours depend on history, and only the directed scenarios show them. These include the lowest-index rule for simultaneous reports and ties resolving toward the incumbent. They also cover a silent incumbent group raising the bar that a later challenger fails to clear, the two-observation PI commit and restart, and the name switching to the new winner's store after a take-over.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int unsigned PI_W    = 16;
    localparam int unsigned SCORE_W = 16;
    localparam int unsigned TEXT_W  = 16;
    localparam int unsigned SEG_N   = 4;
    localparam int unsigned SEG_W   = $clog2(SEG_N);
    localparam int unsigned NAME_W  = SEG_N * TEXT_W;

    typedef struct packed {
        logic [PI_W-1:0]    pi;
        logic [SEG_W-1:0]   seg;
        logic [TEXT_W-1:0]  text;
        logic [SCORE_W-1:0] score;
        logic               changed;
    } grp_t;

    // Candidate may act: any one without incumbent, the incumbent always,
    // a challenger only by strictly exceeding the best score.
    function automatic logic may_act(input logic has_inc, input logic is_inc,
                                     input logic [SCORE_W-1:0] score,
                                     input logic [SCORE_W-1:0] best);
        return !has_inc || is_inc || (score > best);
    endfunction
endpackage

// File: rtl/arb_pick.sv
module arb_pick
    import arb_pkg::*;
#(
    parameter int unsigned N_CAND = 8,
    localparam int unsigned IDX_W = $clog2(N_CAND)
) (
    input  logic [N_CAND-1:0]  valid,
    input  grp_t               grp [N_CAND],
    input  logic               has_inc,
    input  logic [IDX_W-1:0]   inc_idx,
    input  logic [SCORE_W-1:0] best,
    output logic               act,
    output logic [IDX_W-1:0]   act_idx
);
    always_comb begin
        act     = 1'b0;
        act_idx = '0;
        // Scan downward so the lowest eligible index is left standing.
        for (int i = N_CAND - 1; i >= 0; i--) begin
            if (valid[i] && may_act(has_inc, IDX_W'(i) == inc_idx,
                                    grp[i].score, best)) begin
                act     = 1'b1;
                act_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/seg_store.sv
module seg_store
    import arb_pkg::*;
#(
    parameter int unsigned N_CAND = 8,
    localparam int unsigned IDX_W = $clog2(N_CAND)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_CAND-1:0]  valid,
    input  grp_t               grp [N_CAND],
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               all_seen,
    output logic [NAME_W-1:0]  name
);
    logic [SEG_N-1:0]  seen [N_CAND];
    logic [TEXT_W-1:0] text [N_CAND][SEG_N];

    for (genvar c = 0; c < N_CAND; c++) begin : g_cand
        always_ff @(posedge clk) begin
            if (rst) begin
                seen[c] <= '0;
            end else if (valid[c] && grp[c].changed) begin
                seen[c][grp[c].seg] <= 1'b1;
            end
        end
        for (genvar s = 0; s < SEG_N; s++) begin : g_seg
            always_ff @(posedge clk) begin
                if (rst) begin
                    text[c][s] <= '0;
                end else if (valid[c] && grp[c].changed &&
                             grp[c].seg == SEG_W'(s)) begin
                    text[c][s] <= grp[c].text;
                end
            end
        end
    end

    assign all_seen = &seen[rd_idx];

    always_comb begin
        for (int s = 0; s < SEG_N; s++) begin
            name[NAME_W-1-s*TEXT_W -: TEXT_W] = text[rd_idx][s];
        end
    end
endmodule

// File: rtl/pi_confirm.sv
module pi_confirm
    import arb_pkg::*;
#(
    parameter int unsigned CONFIRM = 2,
    localparam int unsigned CNT_W  = $clog2(CONFIRM + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            obs_en,
    input  logic [PI_W-1:0] obs_pi,
    output logic            pi_valid,
    output logic [PI_W-1:0] pi_code
);
    logic [PI_W-1:0]  pend_pi;
    logic [CNT_W-1:0] pend_cnt;
    logic [CNT_W-1:0] next_cnt;
    logic             match;

    assign match    = (pend_cnt != '0) && (obs_pi == pend_pi);
    assign next_cnt = !match ? CNT_W'(1)
                    : (pend_cnt == CNT_W'(CONFIRM)) ? pend_cnt
                    : pend_cnt + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_pi  <= '0;
            pend_cnt <= '0;
            pi_valid <= 1'b0;
            pi_code  <= '0;
        end else if (obs_en) begin
            pend_pi  <= obs_pi;
            pend_cnt <= next_cnt;
            if (next_cnt >= CNT_W'(CONFIRM)) begin
                pi_valid <= 1'b1;
                pi_code  <= obs_pi;
            end
        end
    end

    // R6: committed code moves only right after an observation
    a_r6_commit_needs_obs: assert property (@(posedge clk) disable iff (rst)
        $rose(pi_valid) |-> $past(obs_en));
    a_r6_code_moves_on_obs: assert property (@(posedge clk) disable iff (rst)
        (pi_valid && !$stable(pi_code)) |-> $past(obs_en));
endmodule

// File: rtl/cand_arbiter.sv
module cand_arbiter
    import arb_pkg::*;
#(
    parameter int unsigned N_CAND     = 8,
    parameter int unsigned PI_CONFIRM = 2,
    localparam int unsigned IDX_W     = $clog2(N_CAND)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_CAND-1:0]         grp_valid,
    input  logic [N_CAND*PI_W-1:0]    grp_pi,
    input  logic [N_CAND*SEG_W-1:0]   grp_seg,
    input  logic [N_CAND*TEXT_W-1:0]  grp_text,
    input  logic [N_CAND*SCORE_W-1:0] grp_score,
    input  logic [N_CAND-1:0]         grp_changed,
    output logic                      sel_valid,
    output logic [IDX_W-1:0]          sel_idx,
    output logic                      pi_valid,
    output logic [PI_W-1:0]           pi_code,
    output logic                      ps_valid,
    output logic [NAME_W-1:0]         ps_name
);
    grp_t               grp [N_CAND];
    logic               act;
    logic [IDX_W-1:0]   act_idx;
    logic [SCORE_W-1:0] best_q;
    logic               obs_en;
    logic               all_seen;

    for (genvar c = 0; c < N_CAND; c++) begin : g_unpack
        assign grp[c] = '{pi:      grp_pi[c*PI_W +: PI_W],
                          seg:     grp_seg[c*SEG_W +: SEG_W],
                          text:    grp_text[c*TEXT_W +: TEXT_W],
                          score:   grp_score[c*SCORE_W +: SCORE_W],
                          changed: grp_changed[c]};
    end

    arb_pick #(.N_CAND(N_CAND)) u_pick (
        .valid   (grp_valid),
        .grp     (grp),
        .has_inc (sel_valid),
        .inc_idx (sel_idx),
        .best    (best_q),
        .act     (act),
        .act_idx (act_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_valid <= 1'b0;
            sel_idx   <= '0;
            best_q    <= '0;
        end else if (act) begin
            sel_valid <= 1'b1;
            sel_idx   <= act_idx;
            best_q    <= grp[act_idx].score;
        end
    end

    assign obs_en = act && grp[act_idx].changed && (grp[act_idx].score >= best_q);

    pi_confirm #(.CONFIRM(PI_CONFIRM)) u_pi (
        .clk      (clk),
        .rst      (rst),
        .obs_en   (obs_en),
        .obs_pi   (grp[act_idx].pi),
        .pi_valid (pi_valid),
        .pi_code  (pi_code)
    );

    seg_store #(.N_CAND(N_CAND)) u_store (
        .clk      (clk),
        .rst      (rst),
        .valid    (grp_valid),
        .grp      (grp),
        .rd_idx   (sel_idx),
        .all_seen (all_seen),
        .name     (ps_name)
    );

    assign ps_valid = sel_valid && all_seen;

    // R2: an incumbent, once chosen, persists until reset
    a_r2_incumbent_sticky: assert property (@(posedge clk) disable iff (rst)
        sel_valid |=> sel_valid);
    // R4: every change of incumbent comes with a strictly larger best score
    a_r4_switch_strict: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && $past(sel_valid) && sel_idx != $past(sel_idx))
            |-> best_q > $past(best_q));
    // R8: no name without an incumbent
    a_r8_name_needs_inc: assert property (@(posedge clk) disable iff (rst)
        ps_valid |-> sel_valid);
endmodule

// File: tb/cand_arbiter_test.sv
module cand_arbiter_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    grp_valid = '0;
    logic [N*16-1:0] grp_pi = '0;
    logic [N*2-1:0]  grp_seg = '0;
    logic [N*16-1:0] grp_text = '0;
    logic [N*16-1:0] grp_score = '0;
    logic [N-1:0]    grp_changed = '0;
    logic            sel_valid;
    logic [2:0]      sel_idx;
    logic            pi_valid;
    logic [15:0]     pi_code;
    logic            ps_valid;
    logic [63:0]     ps_name;

    int n_tests = 0;
    int n_fail  = 0;

    cand_arbiter uut (
        .clk(clk), .rst(rst), .grp_valid(grp_valid), .grp_pi(grp_pi),
        .grp_seg(grp_seg), .grp_text(grp_text), .grp_score(grp_score),
        .grp_changed(grp_changed), .sel_valid(sel_valid), .sel_idx(sel_idx),
        .pi_valid(pi_valid), .pi_code(pi_code), .ps_valid(ps_valid),
        .ps_name(ps_name)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] txt(input int c, input int s);
        return {8'(8'h41 + c), 8'(8'h30 + s)};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input int c, input logic [15:0] pi, input int s,
                        input logic [15:0] score, input logic chg);
        grp_valid[c]          = 1'b1;
        grp_pi[c*16 +: 16]    = pi;
        grp_seg[c*2 +: 2]     = 2'(s);
        grp_text[c*16 +: 16]  = txt(c, s);
        grp_score[c*16 +: 16] = score;
        grp_changed[c]        = chg;
    endtask

    task automatic pulse();
        @(negedge clk);
        grp_valid = '0;
    endtask

    task automatic send(input int c, input logic [15:0] pi, input int s,
                        input logic [15:0] score, input logic chg);
        load(c, pi, s, score, chg);
        pulse();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R1 sel_valid", 64'(sel_valid), 64'd0);
        chk("R1 pi_valid",  64'(pi_valid),  64'd0);
        chk("R1 ps_valid",  64'(ps_valid),  64'd0);
    endtask

    task automatic t_first_incumbent();
        load(5, 16'h1234, 0, 16'd20, 1'b1);
        load(3, 16'h1234, 0, 16'd10, 1'b1);
        pulse();
        chk("R2 sel_valid", 64'(sel_valid), 64'd1);
        chk("R2 R9 lowest index wins", 64'(sel_idx), 64'd3);
        chk("R6 single obs not committed", 64'(pi_valid), 64'd0);
    endtask

    task automatic t_tie_and_tracking();
        send(5, 16'h1234, 1, 16'd10, 1'b1);
        chk("R4 tie keeps incumbent", 64'(sel_idx), 64'd3);
        send(3, 16'h1234, 0, 16'd30, 1'b0);
        chk("R5 silent group keeps incumbent", 64'(sel_idx), 64'd3);
        chk("R5 silent group is no PI obs", 64'(pi_valid), 64'd0);
        send(5, 16'h1234, 1, 16'd25, 1'b1);
        chk("R5 tracked score blocks challenger", 64'(sel_idx), 64'd3);
    endtask

    task automatic t_pi_commit();
        send(3, 16'h1234, 1, 16'd30, 1'b1);
        chk("R3 R6 equal-score obs commits", 64'(pi_valid), 64'd1);
        chk("R6 pi_code", 64'(pi_code), 64'h1234);
        send(3, 16'hBEEF, 1, 16'd30, 1'b1);
        chk("R6 new value held back", 64'(pi_code), 64'h1234);
        send(3, 16'hBEEF, 1, 16'd30, 1'b1);
        chk("R6 new value committed", 64'(pi_code), 64'hBEEF);
    endtask

    task automatic t_name_assembly();
        chk("R8 two segments no name", 64'(ps_valid), 64'd0);
        send(3, 16'hBEEF, 2, 16'd30, 1'b1);
        chk("R8 three segments no name", 64'(ps_valid), 64'd0);
        send(3, 16'hBEEF, 3, 16'd30, 1'b1);
        chk("R8 four segments name valid", 64'(ps_valid), 64'd1);
        chk("R7 R8 name order", ps_name, {txt(3,0), txt(3,1), txt(3,2), txt(3,3)});
    endtask

    task automatic t_takeover();
        send(5, 16'hBEEF, 1, 16'd31, 1'b1);
        chk("R4 strictly greater takes over", 64'(sel_idx), 64'd5);
        chk("R10 new incumbent incomplete", 64'(ps_valid), 64'd0);
        send(3, 16'hBEEF, 2, 16'd31, 1'b1);
        chk("R4 former incumbent tie", 64'(sel_idx), 64'd5);
        send(5, 16'hBEEF, 2, 16'd31, 1'b1);
        send(5, 16'hBEEF, 3, 16'd31, 1'b1);
        chk("R10 new incumbent name valid", 64'(ps_valid), 64'd1);
        chk("R10 R7 new incumbent text", ps_name, {txt(5,0), txt(5,1), txt(5,2), txt(5,3)});
    endtask

    task automatic t_same_cycle_challengers();
        load(2, 16'h0001, 0, 16'd50, 1'b1);
        load(1, 16'h0001, 0, 16'd50, 1'b1);
        pulse();
        chk("R9 lowest challenger acts", 64'(sel_idx), 64'd1);
    endtask

    task automatic t_reset_again();
        do_reset();
        chk("R1 reset clears incumbent", 64'(sel_valid), 64'd0);
        chk("R1 reset clears pi", 64'(pi_valid), 64'd0);
        send(0, 16'h0002, 0, 16'd0, 1'b1);
        chk("R1 R7 flags cleared", 64'(ps_valid), 64'd0);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_first_incumbent();
        t_tie_and_tracking();
        t_pi_commit();
        t_name_assembly();
        t_takeover();
        t_same_cycle_challengers();
        t_reset_again();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule